// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of byte slots on its own once software has loaded it. Each slot holds one transmit byte, one command byte and one received byte. Software fills the transmit and command storage over a small register bus and sets a first-slot and a last-slot pointer. It then sets the enable bit. The controller shifts the selected slots out on `mosi` in SPI mode 0, most significant bit first. It captures `miso` into receive storage, then clears the enable bit and raises a finished flag.

Chip select is active low. A continue bit in each command byte keeps it asserted from one slot to the next. A hold bit in the control register keeps it asserted after the run ends, so a transfer longer than the queue can span several runs. A lock register lets software drop a held chip select between runs.

Top module: `qspi_master`

## Requirements
- R1: After reset the control and status registers read 0, the half-period register reads 4, `cs_n` is 1 and `sclk` is 0.
- R2: Word map, data in bits 7:0: transmit byte of slot i at word 2*i, receive byte of slot i at word 32+2*i+1, command byte of slot i at 64+i, first-slot pointer 80, last-slot pointer 81, control 82 (bit 0 enable, bit 1 hold after run), status 83 (bit 0 finished), lock 84 (bit 0), half-period 85. Unused words in the transmit and receive areas read 0. Writes take effect at the clock edge where `bus_valid` and `bus_write` are both 1, and read data is combinational.
- R3: Writing control with bit 0 set starts a run, and the enable bit reads 1 while the run is active. At the end of the run hardware clears enable and sets finished. Writing status with bit 0 at 0 clears finished.
- R4: A run transfers the slots from the first-slot pointer through the last-slot pointer inclusive, in ascending order. The byte received for each slot is stored at that slot's receive word.
- R5: Shifting follows SPI mode 0: `sclk` idles low and is never high while `cs_n` is 1. Data is sent MSB first, `miso` is sampled as `sclk` rises, and `mosi` changes only while `sclk` is low.
- R6: Command bit 7 set keeps `cs_n` low between that slot and the next one. With it clear, `cs_n` goes high between the two slots.
- R7: With control bit 1 set when the run starts, `cs_n` stays low after the run ends, and a following run does not produce a new falling edge. With it clear, `cs_n` is 1 after the run.
- R8: The lock register reads back bit 0. Writing it with 0 while no run is active releases a held chip select in the next cycle.
- R9: One `sclk` period inside a byte lasts 2*H system clocks, where H is the half-period register value, and a value of 0 acts as 1.
- R10: From the falling edge of `cs_n` to the first rising edge of `sclk` takes 1+H clocks, or 1+2*H clocks when command bit 6 of the slot is set.
- R11: While enable is 1, writes to the transmit and command storage, both pointers, the half-period register and control are ignored.
- R12: If the first-slot pointer is greater than the last-slot pointer, the run finishes at once with finished set and no byte shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A sequencer that stepped to the wrong slot would show in the bytes a serial slave receives during that same run. It would also show in the receive words read back right after enable drops. A chip-select flag left in the wrong state shows as an extra or a missing falling edge of `cs_n`, or as `cs_n` still low once a run has finished. A counter mistake in the shift engine changes the measured `sclk` period or lead time in the very next byte. A lost finished or enable update shows at the next status or control read.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_t;
    typedef enum logic [1:0] {SQ_IDLE, SQ_SHIFT, SQ_GAP} sq_state_t;
    localparam int CMD_CONT_BIT  = 7;
    localparam int CMD_LEAD_BIT  = 6;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_HOLD_BIT = 1;
endpackage

// File: rtl/qspi_shift.sv
module qspi_shift
    import qspi_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        tx_byte,
    input  logic [HALF_W-1:0] half,
    input  logic              long_lead,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [7:0]        rx_byte
);
    typedef struct packed {
        sh_state_t       st;
        logic [HALF_W:0] cnt;
        logic [2:0]      bitn;
        logic [7:0]      tx;
        logic [7:0]      rx;
        logic            sclk;
        logic            done;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            SH_IDLE: begin
                if (start) begin
                    s_d.tx   = tx_byte;
                    s_d.bitn = 3'd0;
                    s_d.cnt  = long_lead ? {half, 1'b0} : {1'b0, half};
                    s_d.sclk = 1'b0;
                    s_d.st   = SH_LOW;
                end
            end
            SH_LOW: begin
                if (s_q.cnt <= 1) begin
                    s_d.sclk = 1'b1;
                    s_d.rx   = {s_q.rx[6:0], miso};
                    s_d.cnt  = {1'b0, half};
                    s_d.st   = SH_HIGH;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SH_HIGH: begin
                if (s_q.cnt <= 1) begin
                    s_d.sclk = 1'b0;
                    if (s_q.bitn == 3'd7) begin
                        s_d.done = 1'b1;
                        s_d.st   = SH_IDLE;
                    end else begin
                        s_d.bitn = s_q.bitn + 3'd1;
                        s_d.tx   = {s_q.tx[6:0], 1'b0};
                        s_d.cnt  = {1'b0, half};
                        s_d.st   = SH_LOW;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk    = s_q.sclk;
    assign mosi    = s_q.tx[7];
    assign done    = s_q.done;
    assign rx_byte = s_q.rx;

    // R5: data line must hold still for the whole high phase
    p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sclk && $past(s_q.sclk)) |-> $stable(s_q.tx[7]));
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int HALF_W = 8,
    localparam int PTR_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PTR_W-1:0]  new_ptr,
    input  logic [PTR_W-1:0]  end_ptr,
    input  logic              hold_after,
    input  logic              release_cs,
    input  logic [HALF_W-1:0] half,
    input  logic              cmd_cont,
    input  logic              sh_done,
    output logic [PTR_W-1:0]  slot,
    output logic              sh_start,
    output logic              cs_on,
    output logic              rx_we,
    output logic              run_done
);
    typedef struct packed {
        sq_state_t         st;
        logic [PTR_W-1:0]  slot;
        logic              cs_on;
        logic              start;
        logic              done;
        logic [HALF_W-1:0] gap;
    } sq_t;

    sq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.done  = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (go) begin
                    if (new_ptr > end_ptr) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.slot  = new_ptr;
                        s_d.cs_on = 1'b1;
                        s_d.start = 1'b1;
                        s_d.st    = SQ_SHIFT;
                    end
                end else if (release_cs) begin
                    s_d.cs_on = 1'b0;
                end
            end
            SQ_SHIFT: begin
                if (sh_done) begin
                    if (s_q.slot == end_ptr) begin
                        s_d.done  = 1'b1;
                        s_d.cs_on = hold_after;
                        s_d.st    = SQ_IDLE;
                    end else if (cmd_cont) begin
                        s_d.slot  = s_q.slot + 1'b1;
                        s_d.start = 1'b1;
                    end else begin
                        s_d.slot  = s_q.slot + 1'b1;
                        s_d.cs_on = 1'b0;
                        s_d.gap   = half;
                        s_d.st    = SQ_GAP;
                    end
                end
            end
            SQ_GAP: begin
                if (s_q.gap <= 1) begin
                    s_d.cs_on = 1'b1;
                    s_d.start = 1'b1;
                    s_d.st    = SQ_SHIFT;
                end else begin
                    s_d.gap = s_q.gap - 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign slot     = s_q.slot;
    assign sh_start = s_q.start;
    assign cs_on    = s_q.cs_on;
    assign rx_we    = (s_q.st == SQ_SHIFT) && sh_done;
    assign run_done = s_q.done;

    // R4: the active slot never runs past the last-slot pointer
    p_slot_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_SHIFT) |-> (s_q.slot <= end_ptr));
    // R12: an inverted pointer pair ends the run on the next cycle
    p_empty_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_IDLE && go && new_ptr > end_ptr) |=> run_done);
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int HALF_W = 8,
    localparam int PTR_W  = $clog2(SLOTS),
    localparam int AW     = $clog2(5 * SLOTS + 6)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);
    localparam int A_RX   = 2 * SLOTS;
    localparam int A_CMD  = 4 * SLOTS;
    localparam int A_NEWQ = 5 * SLOTS;
    localparam int A_ENDQ = A_NEWQ + 1;
    localparam int A_CTRL = A_NEWQ + 2;
    localparam int A_STAT = A_NEWQ + 3;
    localparam int A_LOCK = A_NEWQ + 4;
    localparam int A_HALF = A_NEWQ + 5;

    typedef struct packed {
        logic [SLOTS-1:0][7:0] tx;
        logic [SLOTS-1:0][7:0] rx;
        logic [SLOTS-1:0][7:0] cmd;
        logic [PTR_W-1:0]      newq;
        logic [PTR_W-1:0]      endq;
        logic [HALF_W-1:0]     half;
        logic                  en;
        logic                  hold;
        logic                  fin;
        logic                  lock;
    } reg_t;

    reg_t r_d, r_q;

    logic             go, release_cs;
    logic [PTR_W-1:0] seq_slot;
    logic             sh_start, sh_done, cs_on, rx_we, run_done;
    logic [7:0]       rx_byte;
    logic [HALF_W-1:0] half_eff;
    logic             wr, in_tx, in_rx, in_cmd;
    logic [PTR_W-1:0] pair_idx, cmd_idx;

    assign wr       = bus_valid && bus_write;
    assign in_tx    = bus_addr < AW'(A_RX);
    assign in_rx    = (bus_addr >= AW'(A_RX)) && (bus_addr < AW'(A_CMD));
    assign in_cmd   = (bus_addr >= AW'(A_CMD)) && (bus_addr < AW'(A_NEWQ));
    assign pair_idx = bus_addr[PTR_W:1];
    assign cmd_idx  = bus_addr[PTR_W-1:0];
    assign half_eff = (r_q.half == '0) ? HALF_W'(1) : r_q.half;

    always_comb begin
        r_d        = r_q;
        go         = 1'b0;
        release_cs = 1'b0;
        if (rx_we) r_d.rx[seq_slot] = rx_byte;
        if (wr) begin
            if (!r_q.en) begin
                if (in_tx && !bus_addr[0]) r_d.tx[pair_idx] = bus_wdata;
                if (in_cmd) r_d.cmd[cmd_idx] = bus_wdata;
                if (bus_addr == AW'(A_NEWQ)) r_d.newq = bus_wdata[PTR_W-1:0];
                if (bus_addr == AW'(A_ENDQ)) r_d.endq = bus_wdata[PTR_W-1:0];
                if (bus_addr == AW'(A_HALF)) r_d.half = bus_wdata[HALF_W-1:0];
                if (bus_addr == AW'(A_CTRL)) begin
                    r_d.hold = bus_wdata[CTRL_HOLD_BIT];
                    if (bus_wdata[CTRL_EN_BIT]) begin
                        r_d.en = 1'b1;
                        go     = 1'b1;
                    end
                end
            end
            if (bus_addr == AW'(A_STAT) && !bus_wdata[0]) r_d.fin = 1'b0;
            if (bus_addr == AW'(A_LOCK)) begin
                r_d.lock = bus_wdata[0];
                if (!bus_wdata[0] && !r_q.en) release_cs = 1'b1;
            end
        end
        if (run_done) begin
            r_d.en  = 1'b0;
            r_d.fin = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.half <= HALF_W'(4);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_tx && !bus_addr[0]) bus_rdata = r_q.tx[pair_idx];
        if (in_rx && bus_addr[0])  bus_rdata = r_q.rx[pair_idx];
        if (in_cmd)                bus_rdata = r_q.cmd[cmd_idx];
        case (bus_addr)
            AW'(A_NEWQ): bus_rdata = 8'(r_q.newq);
            AW'(A_ENDQ): bus_rdata = 8'(r_q.endq);
            AW'(A_CTRL): bus_rdata = {6'd0, r_q.hold, r_q.en};
            AW'(A_STAT): bus_rdata = {7'd0, r_q.fin};
            AW'(A_LOCK): bus_rdata = {7'd0, r_q.lock};
            AW'(A_HALF): bus_rdata = 8'(r_q.half);
            default: ;
        endcase
    end

    qspi_seq #(.SLOTS(SLOTS), .HALF_W(HALF_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go),
        .new_ptr(r_q.newq), .end_ptr(r_q.endq),
        .hold_after(r_q.hold), .release_cs(release_cs), .half(half_eff),
        .cmd_cont(r_q.cmd[seq_slot][CMD_CONT_BIT]), .sh_done(sh_done),
        .slot(seq_slot), .sh_start(sh_start), .cs_on(cs_on),
        .rx_we(rx_we), .run_done(run_done)
    );

    qspi_shift #(.HALF_W(HALF_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start),
        .tx_byte(r_q.tx[seq_slot]), .half(half_eff),
        .long_lead(r_q.cmd[seq_slot][CMD_LEAD_BIT]), .miso(miso),
        .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(rx_byte)
    );

    assign cs_n = ~cs_on;

    // R5: clock stays low whenever the slave is deselected
    p_cs_sclk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R3: end of run drops enable and raises finished
    p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (!r_q.en && r_q.fin));
    // R11: setup state is frozen while a run is active
    p_frozen_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && $past(r_q.en)) |-> ($stable(r_q.newq) && $stable(r_q.tx) && $stable(r_q.half)));
endmodule

// File: tb/qspi_master_test.sv
`timescale 1ns/1ps
module qspi_master_test;
    localparam int A_RX = 32, A_CMD = 64, A_NQ = 80, A_EQ = 81;
    localparam int A_CTRL = 82, A_STAT = 83, A_LOCK = 84, A_HALF = 85;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, cs_n;
    logic       miso_r = 1'b0;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    qspi_master uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso_r), .cs_n(cs_n)
    );

    function automatic logic [7:0] resp_of(input int n);
        return 8'((n * 29 + 60) & 255);
    endfunction

    // behavioural serial slave and line monitor
    logic [7:0] got[$];
    logic [7:0] s_cur, s_sh;
    int  s_bit = 0, s_idx = 0, s_n = 0, cs_falls = 0;
    bit  s_need = 1'b1, lead_armed = 1'b0;
    time t_csfall = 0, lead = 0, last_rise = 0, min_per = 0;
    bit  have_rise = 1'b0;

    task automatic slave_load();
        s_cur  = resp_of(s_n);
        s_n++;
        s_idx  = 0;
        miso_r = s_cur[7];
        s_need = 1'b0;
    endtask

    always @(negedge cs_n) begin
        cs_falls++;
        t_csfall   = $time;
        lead_armed = 1'b1;
        if (s_need) slave_load();
    end

    always @(posedge sclk) begin
        if (lead_armed) begin
            lead       = $time - t_csfall;
            lead_armed = 1'b0;
        end
        if (have_rise && ($time - last_rise) < min_per) min_per = $time - last_rise;
        last_rise = $time;
        have_rise = 1'b1;
        s_sh = {s_sh[6:0], mosi};
        s_bit++;
        if (s_bit == 8) begin
            got.push_back(s_sh);
            s_bit  = 0;
            s_need = 1'b1;
        end
    end

    always @(negedge sclk) begin
        if (s_need) slave_load();
        else begin
            s_idx++;
            miso_r = s_cur[7 - s_idx];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // every clock: deselected line must have idle clock (R5)
    always @(negedge clk) begin
        if (rst_n) chk("R5 sclk idle while deselected", int'(cs_n && sclk), 0);
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 7'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 7'(a);
        #1;
        d = int'(bus_rdata);
        bus_valid = 1'b0;
    endtask

    task automatic wait_done();
        int v;
        for (int i = 0; i < 5000; i++) begin
            rd(A_CTRL, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic arm_timing();
        have_rise = 1'b0;
        min_per   = 1_000_000;
    endtask

    initial begin
        #1_200_000;
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, base, falls0;
        logic [7:0] txv[4];
        txv[0] = 8'h81; txv[1] = 8'h3C; txv[2] = 8'hF0; txv[3] = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 control", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_HALF, v); chk("R1 half", v, 4);
        rd(A_LOCK, v); chk("R1 lock", v, 0);
        chk("R1 cs_n", int'(cs_n), 1);
        chk("R1 sclk", int'(sclk), 0);

        // chained run of four slots
        wr(A_HALF, 2);
        for (int i = 0; i < 4; i++) begin
            wr(2 * i, txv[i]);
            wr(A_CMD + i, (i < 3) ? 8'h80 : 8'h00);
        end
        wr(A_NQ, 0); wr(A_EQ, 3);
        rd(0, v); chk("R2 tx readback", v, 8'h81);
        rd(1, v); chk("R2 odd tx word", v, 0);
        falls0 = cs_falls; base = got.size(); arm_timing();
        wr(A_CTRL, 1);
        rd(A_CTRL, v); chk("R3 enable while running", v & 1, 1);
        wait_done();
        rd(A_STAT, v); chk("R3 finished", v, 1);
        chk("R4 byte count", got.size() - base, 4);
        for (int i = 0; i < 4; i++) begin
            if (got.size() > base + i) chk("R5 msb-first byte", int'(got[base + i]), int'(txv[i]));
            rd(A_RX + 2 * i + 1, v); chk("R4 rx slot", v, int'(resp_of(base + i)));
        end
        rd(A_RX + 2, v); chk("R2 even rx word", v, 0);
        chk("R6 one select for chained slots", cs_falls - falls0, 1);
        chk("R9 period half=2", int'(min_per), 32);
        chk("R7 released after run", int'(cs_n), 1);
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R3 finished cleared", v, 0);

        // separate selects per slot
        for (int i = 0; i < 3; i++) wr(A_CMD + i, 0);
        wr(A_EQ, 2);
        falls0 = cs_falls; base = got.size();
        wr(A_CTRL, 1); wait_done();
        chk("R6 select per slot", cs_falls - falls0, 3);
        if (got.size() > base + 2) chk("R6 third byte", int'(got[base + 2]), 8'hF0);

        // divider of zero acts as one
        wr(A_HALF, 0); wr(A_EQ, 0); arm_timing();
        wr(A_CTRL, 1); wait_done();
        chk("R9 period half=0", int'(min_per), 16);

        // lead time with and without extended delay
        wr(A_HALF, 3);
        wr(A_CTRL, 1); wait_done();
        chk("R10 lead normal", int'(lead), 32);
        wr(A_CMD, 8'h40);
        wr(A_CTRL, 1); wait_done();
        chk("R10 lead extended", int'(lead), 56);

        // hold across runs
        wr(A_HALF, 1);
        wr(A_CMD + 0, 8'h80); wr(A_CMD + 1, 0);
        wr(A_CMD + 2, 8'h80); wr(A_CMD + 3, 0);
        wr(A_NQ, 0); wr(A_EQ, 1);
        falls0 = cs_falls;
        wr(A_CTRL, 3); wait_done();
        chk("R7 held after run", int'(cs_n), 0);
        wr(A_NQ, 2); wr(A_EQ, 3);
        wr(A_CTRL, 1); wait_done();
        chk("R7 no new select edge", cs_falls - falls0, 1);
        chk("R7 released after final run", int'(cs_n), 1);

        // lock release
        wr(A_CTRL, 3); wait_done();
        wr(A_LOCK, 1);
        rd(A_LOCK, v); chk("R8 lock readback", v, 1);
        chk("R8 still held", int'(cs_n), 0);
        wr(A_LOCK, 0);
        chk("R8 released by lock", int'(cs_n), 1);

        // writes ignored while running
        wr(A_HALF, 8); wr(0, 8'h11); wr(A_CMD, 8'h80);
        wr(A_NQ, 0); wr(A_EQ, 1);
        base = got.size();
        wr(A_CTRL, 1);
        wr(0, 8'hEE); wr(A_NQ, 5); wr(A_HALF, 1); wr(A_CMD, 0);
        wait_done();
        rd(0, v); chk("R11 tx kept", v, 8'h11);
        rd(A_NQ, v); chk("R11 pointer kept", v, 0);
        rd(A_HALF, v); chk("R11 half kept", v, 8);
        rd(A_CMD, v); chk("R11 cmd kept", v, 8'h80);
        if (got.size() > base) chk("R11 shifted old byte", int'(got[base]), 8'h11);

        // empty run
        wr(A_STAT, 0); wr(A_NQ, 3); wr(A_EQ, 1);
        falls0 = cs_falls; base = got.size();
        wr(A_CTRL, 1); wait_done();
        rd(A_STAT, v); chk("R12 finished", v, 1);
        chk("R12 no bytes", got.size() - base, 0);
        chk("R12 no select", cs_falls - falls0, 0);

        // run starting mid-queue
        wr(A_HALF, 2);
        wr(10, 8'hC3); wr(12, 8'h96);
        wr(A_CMD + 5, 8'h80); wr(A_CMD + 6, 0);
        wr(A_NQ, 5); wr(A_EQ, 6);
        base = got.size();
        wr(A_CTRL, 1); wait_done();
        chk("R4 mid-queue count", got.size() - base, 2);
        if (got.size() > base + 1) begin
            chk("R4 slot5 byte", int'(got[base]), 8'hC3);
            chk("R4 slot6 byte", int'(got[base + 1]), 8'h96);
        end
        rd(A_RX + 11, v); chk("R4 rx slot5", v, int'(resp_of(base)));
        rd(A_RX + 13, v); chk("R4 rx slot6", v, int'(resp_of(base + 1)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule